// File: doc/BRIEF.md
# Binary-to-Ternary Sigma-Delta Re-modulator

This block accepts a one-bit stream whose symbols stand for +1 and −1 and turns it into a three-level stream (+1, 0, −1) through a first-order sigma-delta loop. Every node of the loop is a trit, and no multibit accumulator appears anywhere. The loop has two parts. A difference stage subtracts the previously emitted trit from the incoming symbol. An integrator stage adds the result to that same previous trit. Each stage is a ternary adder that keeps its own one-trit carry memory. When a sum overflows the trit range, the stage saves the excess and spends it on a later sample, so it does not have to drop it.

The stream advances one sample on every cycle in which the clock enable is high. Between enabled cycles the output and all internal state are held. The output trit is registered, so the feedback path carries exactly one sample of delay. A synchronous reset clears the output and both carry memories to zero.

Top module: `tsdm_bin2tern`

## Requirements
- R1: When `rst` is high at a rising clock edge, the output and both carry memories become 0 regardless of `en`, and the next enabled sample behaves as the first sample after start-up.
- R2: Input bit 1 stands for +1 and input bit 0 stands for −1. From the cleared state, one enabled sample with bit 1 yields output +1, and one with bit 0 yields output −1.
- R3: The output trit is coded in 2-bit two's complement: 2'b01 = +1, 2'b00 = 0, 2'b11 = −1. The code 2'b10 never appears.
- R4: In a cycle with `en` low and `rst` low, the output and the internal state do not change. The output after the gap equals the output the same input sequence gives with no gap.
- R5: Each ternary adder, with operands a and b and carry memory d, computes the following. First u = sgn(a+b) and c1 = a+b−u. Then the sum is s = sgn(u+d) and c2 = u+d−s. The new carry memory is sgn(c1+c2).
- R6: On each enabled sample, the difference stage adds x and the negated previous output, giving g. The integrator stage adds g and the previous output, giving the new output. Each stage uses its own carry memory.
- R7: When both operands and the carry memory of a stage are equal and nonzero, one unit of excess is lost. The stage's sum and its new carry memory both take that common sign.
- R8: A constant input of all ones gives +1 on every sample, and a constant input of all zeros gives −1 on every sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; state advances only when high |
| inBit | input | 1 | Binary symbol: 1 = +1, 0 = −1 |
| tritOut | output | 2 | Registered output trit, two's complement |

## Verification
The hardest state to reach from the ports is the lost-carry case of R7. In the integrator stage it needs the difference result, the previous output and the stored carry to share one nonzero sign. In the difference stage it needs the input symbol to be opposite to the previous output while a carry of the input's sign is still pending. Neither condition can be forced directly. The stimulus therefore runs long pseudo-random streams with biased symbol densities and enable gaps. The bench counts how often its reference model meets the condition, and it requires that count to be nonzero.

// File: rtl/tsdm_pkg.sv
package tsdm_pkg;
  localparam int TRIT_W = 2;
  localparam int WIDE_W = TRIT_W + 1;

  typedef logic signed [TRIT_W-1:0] trit_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam trit_t TRIT_POS  = 2'sb01;
  localparam trit_t TRIT_ZERO = 2'sb00;
  localparam trit_t TRIT_NEG  = 2'sb11;

  typedef struct packed {
    logic advance;
    logic clear;
  } strobe_t;

  function automatic wide_t widen(input trit_t t);
    return {t[TRIT_W-1], t};
  endfunction

  function automatic trit_t signOf(input wide_t v);
    if (v > 0) return TRIT_POS;
    else if (v < 0) return TRIT_NEG;
    else return TRIT_ZERO;
  endfunction
endpackage

// File: rtl/tern_carry_adder.sv
module tern_carry_adder
  import tsdm_pkg::*;
(
  input  trit_t opA,
  input  trit_t opB,
  input  trit_t carryIn,
  output trit_t sumOut,
  output trit_t carryOut
);
  wide_t rawSum;
  trit_t firstSum;
  wide_t spillA;
  wide_t withCarry;
  wide_t spillB;

  always_comb begin
    rawSum    = widen(opA) + widen(opB);
    firstSum  = signOf(rawSum);
    spillA    = rawSum - widen(firstSum);
    withCarry = widen(firstSum) + widen(carryIn);
    sumOut    = signOf(withCarry);
    spillB    = withCarry - widen(sumOut);
    carryOut  = signOf(spillA + spillB);
  end
endmodule

// File: rtl/tsdm_ctrl.sv
module tsdm_ctrl
  import tsdm_pkg::*;
(
  input  logic    rst,
  input  logic    en,
  output strobe_t strobes
);
  always_comb begin
    strobes.clear   = rst;
    strobes.advance = en & ~rst;
  end
endmodule

// File: rtl/tsdm_datapath.sv
module tsdm_datapath
  import tsdm_pkg::*;
(
  input  logic    clk,
  input  strobe_t strobes,
  input  logic    inBit,
  output trit_t   outTrit
);
  trit_t prevOut;
  trit_t diffCarry;
  trit_t intCarry;
  trit_t inTrit;
  trit_t negPrev;
  trit_t diffSum;
  trit_t diffCarryNext;
  trit_t intSum;
  trit_t intCarryNext;

  always_comb begin
    inTrit  = inBit ? TRIT_POS : TRIT_NEG;
    negPrev = -prevOut;
  end

  tern_carry_adder u_diff (
    .opA(inTrit), .opB(negPrev), .carryIn(diffCarry),
    .sumOut(diffSum), .carryOut(diffCarryNext)
  );

  tern_carry_adder u_integ (
    .opA(diffSum), .opB(prevOut), .carryIn(intCarry),
    .sumOut(intSum), .carryOut(intCarryNext)
  );

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      prevOut   <= TRIT_ZERO;
      diffCarry <= TRIT_ZERO;
      intCarry  <= TRIT_ZERO;
    end else if (strobes.advance) begin
      prevOut   <= intSum;
      diffCarry <= diffCarryNext;
      intCarry  <= intCarryNext;
    end
  end

  assign outTrit = prevOut;
endmodule

// File: rtl/tsdm_bin2tern.sv
module tsdm_bin2tern
  import tsdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       inBit,
  output logic [1:0] tritOut
);
  strobe_t strobes;
  trit_t   outTrit;

  tsdm_ctrl u_ctrl (.rst(rst), .en(en), .strobes(strobes));

  tsdm_datapath u_dp (
    .clk(clk), .strobes(strobes), .inBit(inBit), .outTrit(outTrit)
  );

  assign tritOut = outTrit;
endmodule

// File: rtl/tsdm_checker.sv
module tsdm_checker (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       inBit,
  input logic [1:0] tritOut
);
  p_no_bad_code_r3: assert property (@(posedge clk) disable iff (rst)
    tritOut != 2'b10);

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> tritOut == 2'b00);

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(tritOut));

  p_first_pos_r2: assert property (@(posedge clk) disable iff (rst)
    (en && inBit && $past(rst)) |=> tritOut == 2'b01);

  p_first_neg_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !inBit && $past(rst)) |=> tritOut == 2'b11);
endmodule

bind tsdm_bin2tern tsdm_checker u_chk (
  .clk(clk), .rst(rst), .en(en), .inBit(inBit), .tritOut(tritOut)
);

// File: tb/test_tsdm_bin2tern.sv
module test_tsdm_bin2tern;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic inBit = 1'b0;
  logic [1:0] tritOut;

  int checks = 0;
  int failures = 0;
  int lostCount = 0;
  int mOut = 0, mD1 = 0, mD2 = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tsdm_bin2tern i_tsdm_bin2tern (
    .clk(clk), .rst(rst), .en(en), .inBit(inBit), .tritOut(tritOut)
  );

  function automatic int sg(int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic int decode(logic [1:0] c);
    case (c)
      2'b01: return 1;
      2'b11: return -1;
      default: return 0;
    endcase
  endfunction

  // R5/R7 reference: ternary sum with one-trit carry memory
  task automatic tadd(input int a, input int b, inout int d, output int s);
    int u, e1, e2;
    if (a == b && b == d && a != 0) lostCount++;
    u = sg(a + b);
    e1 = a + b - u;
    s = sg(u + d);
    e2 = u + d - s;
    d = sg(e1 + e2);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit e, input bit b);
    int g, s;
    @(negedge clk);
    rst = r; en = e; inBit = b;
    @(posedge clk);
    if (r) begin
      mOut = 0; mD1 = 0; mD2 = 0;
    end else if (e) begin
      tadd(b ? 1 : -1, -mOut, mD1, g);   // R6 difference stage
      tadd(g, mOut, mD2, s);             // R6 integrator stage
      mOut = s;
    end
    #1;
    check(tritOut != 2'b10, "R3", int'(tritOut), 0);
    check(decode(tritOut) == mOut, "R5/R6", decode(tritOut), mOut);
  endtask

  initial begin
    int pre;
    step(1, 0, 0);
    step(1, 1, 1);
    check(tritOut == 2'b00, "R1 reset state", int'(tritOut), 0);
    step(0, 1, 1);
    check(tritOut == 2'b01, "R2 bit1 -> +1", int'(tritOut), 1);
    for (int i = 0; i < 30; i++) begin
      step(0, 1, 1);
      check(tritOut == 2'b01, "R8 constant ones", decode(tritOut), 1);
    end
    step(1, 0, 0);
    step(0, 1, 0);
    check(tritOut == 2'b11, "R2 bit0 -> -1", decode(tritOut), -1);
    for (int i = 0; i < 30; i++) begin
      step(0, 1, 0);
      check(tritOut == 2'b11, "R8 constant zeros", decode(tritOut), -1);
    end
    for (int i = 0; i < 40; i++) step(0, 1, i[0]);
    for (int i = 0; i < 40; i++) step(0, 1, (i % 3) != 0);
    pre = decode(tritOut);
    for (int i = 0; i < 5; i++) begin
      step(0, 0, i[0]);
      check(decode(tritOut) == pre, "R4 hold while disabled", decode(tritOut), pre);
    end
    for (int i = 0; i < 4000; i++) begin
      int dens;
      dens = (i / 500) % 4;
      step((i % 1333) == 700, ($urandom % 5) != 0,
           ($urandom % 8) < (2 + 2 * dens));
    end
    for (int i = 0; i < 10; i++) step(0, 1, 1);
    step(1, 1, 0);
    check(tritOut == 2'b00, "R1 mid-run reset", int'(tritOut), 0);
    check(lostCount > 0, "R7 lost-carry case reached", lostCount, 1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule